// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block turns single read or write requests from a processor core into timed cycles on a 16-bit external bus. It has four chip-select areas. The two most significant address bits pick the area. Each area owns a six-bit configuration word, and that word sets the cycle shape: the number of internal wait clocks, an optional one-clock strobe delay, an optional recovery clock and an optional idle clock. The idle clock is added after reads only. An external active-low wait input can stretch the strobe beyond the internal count.

The core offers a request with `req_valid` while `req_ready` is high. The block latches the request and its area configuration at that edge. It runs the bus cycle and then raises `rsp_done` for one clock. For reads, `rsp_rdata` is valid from that clock on. A static strap selects the byte-lane mode. With the strap set, the byte enables are held for the whole chip-select window. With it clear, they follow the read or write strobe.

The sequencer has five states:
- `ST_IDLE`: ready for a request.
- `ST_SETUP`: chip select active, strobe held back.
- `ST_STROBE`: strobe active while the internal count runs down and then while the wait input is sampled.
- `ST_RECOV`: every pin inactive.
- `ST_REST`: the idle clock after a read.

The transitions are:
- IDLE→SETUP on a request when strobe wait is set, otherwise IDLE→STROBE.
- SETUP→STROBE always.
- STROBE→STROBE while the count is non-zero or the wait input is low.
- STROBE→RECOV, STROBE→REST or STROBE→IDLE on completion, in that order of preference.
- RECOV→REST for a read with idle set, otherwise RECOV→IDLE.
- REST→IDLE always.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: During and after reset, all chip selects, `bus_rd_n`, `bus_wr_n`, `bus_bhe_n` and `bus_ble_n` are high. `bus_doe` and `rsp_done` are low and `req_ready` is high.
- R2: Only the chip select of the addressed area is low, and only during the setup and strobe clocks of a cycle. All chip selects are high otherwise.
- R3: With the wait input high, the strobe lasts 1 + W clocks. W is the 3-bit wait field, bits [2:0] of the area word, with values 0 to 7.
- R4: When the strobe-wait bit (bit 3) is set, one clock with the chip select low and the strobe high comes before the strobe. When the bit is clear, the strobe starts in the first clock.
- R5: The wait input is ignored during the internal wait clocks. On the last strobe clock, each clock in which it is sampled low adds one more strobe clock.
- R6: When the recovery bit (bit 4) is set, one clock with every chip select, strobe and byte enable inactive follows the strobe. This clock comes before any idle clock.
- R7: When the idle bit (bit 5) is set, one more inactive clock follows a read cycle. It never follows a write cycle.
- R8: `bus_rd_n` goes low only in the strobe of a read, and `bus_wr_n` only in the strobe of a write. During a write's setup and strobe clocks, `bus_doe` is high and `bus_dout` carries the request data.
- R9: With `byte_sep` = 1, `bus_bhe_n` = ~be[1] and `bus_ble_n` = ~be[0] for the whole setup-plus-strobe window. With `byte_sep` = 0, they are asserted only while the strobe is low.
- R10: `rsp_done` is high for exactly the one clock after the last strobe clock, for reads and for writes. For a read, `rsp_rdata` holds `bus_din` as sampled at the edge that closes the last strobe clock.
- R11: `req_ready` is high only when the sequencer is idle, and a request is taken only while it is high. Bus occupancy is setup + 1 + W + extensions + recovery + (read and idle) clocks.
- R12: The area is `req_addr[ADDR_W-1:ADDR_W-2]`. Area a's word sits at `area_cfg[6a+5:6a]`. The word and the address are captured when the request is taken, and `bus_addr` holds that address through the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address, top bits select the area |
| req_be | input | 2 | Byte enables, bit 1 high lane, bit 0 low lane |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data captured at completion |
| area_cfg | input | 6*N_AREA | Per-area configuration words |
| byte_sep | input | 1 | Byte-lane mode strap |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | N_AREA | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_bhe_n | output | 1 | Active-low high-byte enable |
| bus_ble_n | output | 1 | Active-low low-byte enable |
| bus_wait_n | input | 1 | Active-low external wait request |
| bus_din | input | 16 | Data from the bus |
| bus_dout | output | 16 | Data to the bus |
| bus_doe | output | 1 | Data output enable |

## Verification
The assertions assume that `area_cfg` and `byte_sep` change only while `req_ready` is high. They also assume that `bus_wait_n` does not hold the strobe forever, and that a request is offered only with `req_ready` high. The bench respects all three. It changes the configuration and the strap only on the idle clock where it presents the next request. It pulls the wait input low for at most two clocks past the internal count, and it keeps it low during the internal wait clocks to show that they ignore it. It presents each request for exactly the one clock in which it is taken.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int XB_DATA_W = 16;
    localparam int XB_WSEL_W = 3;
    localparam int XB_CFG_W  = XB_WSEL_W + 3;

    // Area configuration word, bit 5 down to bit 0
    typedef struct packed {
        logic                 idle;
        logic                 recov;
        logic                 swait;
        logic [XB_WSEL_W-1:0] wsel;
    } xb_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_RECOV  = 3'd3,
        ST_REST   = 3'd4
    } xb_state_e;

endpackage

// File: rtl/xbus_area_sel.sv
module xbus_area_sel
    import xbus_pkg::*;
#(
    parameter int N_AREA = 4,
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [N_AREA*XB_CFG_W-1:0] cfg_flat,
    output xb_cfg_t                    cfg,
    output logic [N_AREA-1:0]          cs_sel
);
    localparam int AREA_W = $clog2(N_AREA);

    logic [AREA_W-1:0] area;
    xb_cfg_t           cfg_arr [N_AREA];

    assign area = addr[ADDR_W-1 -: AREA_W];

    for (genvar i = 0; i < N_AREA; i++) begin : g_area
        assign cfg_arr[i] = cfg_flat[i*XB_CFG_W +: XB_CFG_W];
        assign cs_sel[i]  = (area == AREA_W'(i));
    end

    assign cfg = cfg_arr[area];

endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/xbus_seq_fsm.sv
module xbus_seq_fsm
    import xbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  xb_cfg_t              cfg_in,
    input  xb_cfg_t              cfg_q,
    input  logic                 we_q,
    input  logic                 cnt_zero,
    input  logic                 wait_n,
    output logic                 ready,
    output logic                 in_cyc,
    output logic                 strobe,
    output logic                 cnt_load,
    output logic                 cnt_dec,
    output logic [XB_WSEL_W-1:0] cnt_val,
    output logic                 finish,
    output logic                 done
);
    xb_state_e state, nxt;
    logic      rest_due;

    assign rest_due = !we_q && cfg_q.idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= finish;
        end
    end

    // transitions
    always_comb begin
        nxt    = state;
        finish = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = cfg_in.swait ? ST_SETUP : ST_STROBE;
            end
            ST_SETUP: nxt = ST_STROBE;
            ST_STROBE: begin
                if (cnt_zero && wait_n) begin
                    finish = 1'b1;
                    if (cfg_q.recov)   nxt = ST_RECOV;
                    else if (rest_due) nxt = ST_REST;
                    else               nxt = ST_IDLE;
                end
            end
            ST_RECOV: nxt = rest_due ? ST_REST : ST_IDLE;
            ST_REST:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = (state == ST_IDLE);
        in_cyc   = (state == ST_SETUP) || (state == ST_STROBE);
        strobe   = (state == ST_STROBE);
        cnt_load = (nxt == ST_STROBE) && (state != ST_STROBE);
        cnt_dec  = (state == ST_STROBE);
        cnt_val  = (state == ST_IDLE) ? cfg_in.wsel : cfg_q.wsel;
    end

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int N_AREA = 4,
    parameter int ADDR_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_we,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [XB_DATA_W/8-1:0]        req_be,
    input  logic [XB_DATA_W-1:0]          req_wdata,
    output logic                          rsp_done,
    output logic [XB_DATA_W-1:0]          rsp_rdata,
    input  logic [N_AREA*XB_CFG_W-1:0]    area_cfg,
    input  logic                          byte_sep,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [N_AREA-1:0]             bus_cs_n,
    output logic                          bus_rd_n,
    output logic                          bus_wr_n,
    output logic                          bus_bhe_n,
    output logic                          bus_ble_n,
    input  logic                          bus_wait_n,
    input  logic [XB_DATA_W-1:0]          bus_din,
    output logic [XB_DATA_W-1:0]          bus_dout,
    output logic                          bus_doe
);
    localparam int BE_W = XB_DATA_W / 8;

    xb_cfg_t                cfg_in, cfg_q;
    logic [N_AREA-1:0]      cs_sel, cs_sel_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [BE_W-1:0]        be_q;
    logic [XB_DATA_W-1:0]   wdata_q, rdata_q;
    logic                   we_q, start;
    logic                   in_cyc, strobe, lanes_on;
    logic                   cnt_load, cnt_dec, cnt_zero, finish;
    logic [XB_WSEL_W-1:0]   cnt_val;

    xbus_area_sel #(.N_AREA(N_AREA), .ADDR_W(ADDR_W)) u_sel (
        .addr     (req_addr),
        .cfg_flat (area_cfg),
        .cfg      (cfg_in),
        .cs_sel   (cs_sel)
    );

    xbus_wait_cnt #(.W(XB_WSEL_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    xbus_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg_in),
        .cfg_q    (cfg_q),
        .we_q     (we_q),
        .cnt_zero (cnt_zero),
        .wait_n   (bus_wait_n),
        .ready    (req_ready),
        .in_cyc   (in_cyc),
        .strobe   (strobe),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .cnt_val  (cnt_val),
        .finish   (finish),
        .done     (rsp_done)
    );

    assign start = req_valid && req_ready;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            cs_sel_q <= '0;
            cfg_q    <= '0;
        end else if (start) begin
            addr_q   <= req_addr;
            be_q     <= req_be;
            wdata_q  <= req_wdata;
            we_q     <= req_we;
            cs_sel_q <= cs_sel;
            cfg_q    <= cfg_in;
        end
    end

    // read data capture on the closing edge of the last strobe clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (finish && !we_q)  rdata_q <= bus_din;
    end

    // pin formation
    always_comb begin
        lanes_on  = byte_sep ? in_cyc : strobe;
        bus_addr  = addr_q;
        bus_cs_n  = in_cyc ? ~cs_sel_q : '1;
        bus_rd_n  = !(strobe && !we_q);
        bus_wr_n  = !(strobe && we_q);
        bus_bhe_n = !(lanes_on && be_q[1]);
        bus_ble_n = !(lanes_on && be_q[0]);
        bus_doe   = in_cyc && we_q;
        bus_dout  = wdata_q;
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
    parameter int N_AREA = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [N_AREA-1:0] bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_bhe_n,
    input logic              bus_ble_n,
    input logic              bus_wait_n,
    input logic              bus_doe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&bus_cs_n && bus_rd_n && bus_wr_n && bus_bhe_n && bus_ble_n && !bus_doe));

    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    a_r8_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n));

    a_r8_doe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_rd_n);

    a_r9_lanes_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_bhe_n || !bus_ble_n) |-> !(&bus_cs_n));

    a_r5_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bus_rd_n || !bus_wr_n) && !bus_wait_n) |=> (!bus_rd_n || !bus_wr_n));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.N_AREA(N_AREA)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .bus_cs_n   (bus_cs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_bhe_n  (bus_bhe_n),
    .bus_ble_n  (bus_ble_n),
    .bus_wait_n (bus_wait_n),
    .bus_doe    (bus_doe)
);

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_AREA = 4;
    localparam int ADDR_W = 24;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic                  req_we = 1'b0;
    logic [ADDR_W-1:0]     req_addr = '0;
    logic [1:0]            req_be = '0;
    logic [15:0]           req_wdata = '0;
    logic                  rsp_done;
    logic [15:0]           rsp_rdata;
    logic [N_AREA*6-1:0]   area_cfg = '0;
    logic                  byte_sep = 1'b0;
    logic [ADDR_W-1:0]     bus_addr;
    logic [N_AREA-1:0]     bus_cs_n;
    logic                  bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n;
    logic                  bus_wait_n = 1'b1;
    logic [15:0]           bus_din = '0;
    logic [15:0]           bus_dout;
    logic                  bus_doe;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_wait_ctrl #(.N_AREA(N_AREA), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .area_cfg(area_cfg), .byte_sep(byte_sep),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n),
        .bus_wait_n(bus_wait_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one transaction; entered and left on a negedge with the sequencer idle
    task automatic run_txn(input int area, input int w, input bit sw, input bit rc,
                           input bit id, input bit we, input bit sep, input int ext,
                           input logic [1:0] be, input logic [7:0] tid);
        logic [5:0] word;
        int se, tot;
        logic [ADDR_W-1:0] a;
        word = {id, rc, sw, 3'(w)};
        for (int i = 0; i < N_AREA; i++)
            area_cfg[i*6 +: 6] = (i == area) ? word : ~word;
        a = {2'(area), 22'(tid * 1237 + 5)};
        byte_sep  = sep;
        req_we    = we;
        req_addr  = a;
        req_be    = be;
        req_wdata = {tid, ~tid};
        req_valid = 1'b1;
        chk(req_ready === 1'b1, "R11 ready before request", 32'(req_ready), 1);
        se  = int'(sw) + 1 + w + ext;
        tot = se + int'(rc) + ((!we && id) ? 1 : 0);
        @(posedge clk);
        for (int k = 0; k <= tot; k++) begin
            logic [N_AREA-1:0] e_cs;
            bit incyc, strb, lanes;
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            bus_wait_n = !(k >= int'(sw) && k < se - 1);
            bus_din    = {tid, 8'(k)};
            incyc = (k < se);
            strb  = (k >= int'(sw)) && (k < se);
            lanes = sep ? incyc : strb;
            e_cs  = incyc ? ~(N_AREA'(1) << area) : '1;
            chk(bus_cs_n === e_cs, "R2 R12 chip select", 32'(bus_cs_n), 32'(e_cs));
            chk(bus_rd_n === !(strb && !we), "R3 R4 R5 R8 read strobe", 32'(bus_rd_n), 32'(!(strb && !we)));
            chk(bus_wr_n === !(strb && we), "R3 R4 R5 R8 write strobe", 32'(bus_wr_n), 32'(!(strb && we)));
            chk({bus_bhe_n, bus_ble_n} === ~({2{lanes}} & be), "R9 byte enables",
                32'({bus_bhe_n, bus_ble_n}), 32'(~({2{lanes}} & be)));
            chk(bus_doe === (incyc && we), "R8 data enable", 32'(bus_doe), 32'(incyc && we));
            chk(req_ready === (k == tot), "R6 R7 R11 occupancy", 32'(req_ready), 32'(k == tot));
            chk(rsp_done === (k == se), "R10 done pulse", 32'(rsp_done), 32'(k == se));
            if (k == 0) begin
                chk(bus_addr === a, "R12 address hold", 32'(bus_addr), 32'(a));
                if (we) chk(bus_dout === {tid, ~tid}, "R8 write data", 32'(bus_dout), 32'({tid, ~tid}));
            end
            if (k == se && !we)
                chk(rsp_rdata === {tid, 8'(se - 1)}, "R10 read data", 32'(rsp_rdata), 32'({tid, 8'(se - 1)}));
        end
        bus_wait_n = 1'b1;
    endtask

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(&bus_cs_n && bus_rd_n && bus_wr_n && bus_bhe_n && bus_ble_n, "R1 reset pins", 32'({bus_cs_n, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n}), 32'hFF);
        chk(!bus_doe && !rsp_done && req_ready, "R1 reset handshake", 32'({bus_doe, rsp_done, req_ready}), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int area = 0; area < N_AREA; area++)
            for (int w = 0; w < 8; w++)
                for (int f = 0; f < 32; f++) begin
                    run_txn(area, w, f[0], f[1], f[2], f[3], f[4], idx % 3,
                            2'((idx % 3) + 1), 8'(idx));
                    idx++;
                end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule